// File: doc/BRIEF.md
# Encoded Interrupt Level Decoder

This block turns a 4-bit encoded external interrupt request level into per-source request lines for an interrupt controller. A level of zero means that no request is present. Any nonzero level selects exactly one of fifteen internal sources. The source index is the bitwise inverse of the level within four bits, so the highest-priority level (15) lands on index 0 and the lowest (1) lands on index 14.

When a level is selected, the block raises that source's asserted line. It also forces the source's enable request on, and in the same update it drops every other asserted line. An enable that has been forced on stays on when the level later moves elsewhere or returns to zero; only the asserted line is withdrawn. The level input is sampled once per clock, and the outputs follow one clock after that sample, but only when the sampled level differs from the one last applied.

Top module: `irl_decoder`

## Requirements
- R1: After reset, `srcAsserted` and `srcEnable` are both all zeros.
- R2: A nonzero level L presented on `levelIn` sets `srcAsserted` to a one-hot vector whose single set bit is at index (L XOR 15). Bit i of each output vector corresponds to source index i.
- R3: Level 0 clears every bit of `srcAsserted`.
- R4: Whenever a source is asserted, its bit in `srcEnable` is set by the same update.
- R5: A bit of `srcEnable` never returns to 0 except by reset, whatever the later levels are.
- R6: At most one bit of `srcAsserted` is ever set. A newly selected source replaces the old one in a single update, with no cycle where both or neither are asserted.
- R7: A level held on `levelIn` before a rising edge appears on the outputs after the following rising edge (two edges in all). After the first of those edges the outputs still show the previous state, and a level that is held unchanged leaves both outputs stable.
- R8: The end points of the mapping hold: level 15 asserts index 0 and level 1 asserts index 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| levelIn | input | 4 | Encoded request level, 0 means no request |
| srcAsserted | output | 15 | One-hot asserted line per source |
| srcEnable | output | 15 | Sticky enable request per source |

## Verification
Deasserting the old source and asserting the new one happen in the same update, and forcing the enable falls in that update too. The bench provokes this with back-to-back distinct nonzero levels, and it judges the result after the second edge: exactly the new bit is asserted, and the enable vector is the old one ORed with the new bit. Switching from one level straight to zero, and holding a level across many cycles, set the clear path against the sticky enable. Random levels from a fixed seed are mixed with the directed end points.

// File: rtl/irl_decoder_pkg.sv
package irl_decoder_pkg;
  localparam int LEVEL_W = 4;
  localparam int NUM_SRC = (1 << LEVEL_W) - 1;

  typedef struct packed {
    logic               update;
    logic               clearAll;
    logic [LEVEL_W-1:0] index;
  } irl_strobe_t;
endpackage

// File: rtl/irl_decoder_ctrl.sv
module irl_decoder_ctrl
  import irl_decoder_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] levelIn,
  output irl_strobe_t        stb
);
  logic [LEVEL_W-1:0] levelReg;
  logic [LEVEL_W-1:0] appliedLevel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      levelReg     <= '0;
      appliedLevel <= '0;
    end else begin
      levelReg <= levelIn;
      if (stb.update) appliedLevel <= levelReg;
    end
  end

  always_comb begin
    stb.update   = (levelReg != appliedLevel);
    stb.clearAll = (levelReg == '0);
    stb.index    = levelReg ^ {LEVEL_W{1'b1}};
  end

  // R7: an update is a one-cycle event; the level is then considered applied
  a_r7_single_update: assert property (@(posedge clk) disable iff (!rst_n)
    stb.update && $stable(levelIn) |=> !stb.update);
endmodule

// File: rtl/irl_decoder_dp.sv
module irl_decoder_dp
  import irl_decoder_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  irl_strobe_t        stb,
  output logic [NUM_SRC-1:0] srcAsserted,
  output logic [NUM_SRC-1:0] srcEnable
);
  logic [NUM_SRC-1:0] selVec;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
      assign selVec[i] = !stb.clearAll && (stb.index == LEVEL_W'(i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcAsserted <= '0;
      srcEnable   <= '0;
    end else if (stb.update) begin
      srcAsserted <= selVec;
      srcEnable   <= srcEnable | selVec;
    end
  end

  // R6: never more than one source asserted
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(srcAsserted));
  // R4: an asserted source always has its enable set
  a_r4_enable_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (srcAsserted & ~srcEnable) == '0);
  // R5: enables are sticky
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(srcEnable) & ~srcEnable) == '0);
  // R3: a zero level clears all asserted lines
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stb.update && stb.clearAll |=> srcAsserted == '0);
  // R7: without an update both outputs hold
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.update |=> $stable(srcAsserted) && $stable(srcEnable));
endmodule

// File: rtl/irl_decoder.sv
module irl_decoder
  import irl_decoder_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         levelIn,
  output logic [14:0]        srcAsserted,
  output logic [14:0]        srcEnable
);
  irl_strobe_t stb;

  irl_decoder_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .levelIn(levelIn), .stb(stb)
  );

  irl_decoder_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .srcAsserted(srcAsserted), .srcEnable(srcEnable)
  );
endmodule

// File: tb/irl_decoder_tb.sv
`timescale 1ns/1ps
module irl_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  levelIn = '0;
  logic [14:0] srcAsserted, srcEnable;
  logic [14:0] expAsserted = '0, expEnable = '0;
  int testCount = 0, failCount = 0;
  bit done = 0;

  irl_decoder u_dut (.clk(clk), .rst_n(rst_n), .levelIn(levelIn),
                     .srcAsserted(srcAsserted), .srcEnable(srcEnable));

  always #2.5 clk = ~clk;

  function automatic logic [14:0] modelSel(input logic [3:0] lvl);
    logic [14:0] v = '0;
    if (lvl != 0) v[15 - int'(lvl)] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check intermediate after 1 edge, result after 2 edges
  task automatic apply(input logic [3:0] lvl, input string req);
    logic [14:0] prevA = expAsserted, prevE = expEnable;
    levelIn = lvl;
    @(negedge clk);
    if (lvl != levelIn || 1) begin
      check("R7 hold-asserted", srcAsserted, prevA);
      check("R7 hold-enable", srcEnable, prevE);
    end
    @(negedge clk);
    expAsserted = modelSel(lvl);
    expEnable   = prevE | modelSel(lvl);
    check({req, " asserted"}, srcAsserted, expAsserted);
    check({req, " R4/R5 enable"}, srcEnable, expEnable);
  endtask

  initial begin
    int seed = 32'h1d5;
    void'($urandom(seed));
    @(negedge clk);
    check("R1 asserted", srcAsserted, '0);
    check("R1 enable", srcEnable, '0);
    rst_n = 1'b1;
    @(negedge clk);
    apply(4'd15, "R8 level15");
    apply(4'd1,  "R8 level1 R6");
    apply(4'd0,  "R3 zero");
    apply(4'd7,  "R2 level7");
    apply(4'd8,  "R6 switch");
    repeat (4) begin
      @(negedge clk);
      check("R7 steady asserted", srcAsserted, expAsserted);
      check("R7 steady enable", srcEnable, expEnable);
    end
    apply(4'd0,  "R3 zero again");
    for (int n = 0; n < 300; n++) begin
      logic [3:0] lvl = 4'($urandom_range(0, 15));
      apply(lvl, "R2 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        testCount++;
        failCount++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule